// File: doc/BRIEF.md
# Phase-Continuous FSK Tone Synthesizer

This block turns a serial transmit bit into a stepped sine tone for a two-tone frequency-shift-keyed link, using only a master clock. A reloadable counter divides the master clock by one of two ratios, picked by the transmit bit. Each time that counter wraps, a 16-step phase index moves on by one. The index is mapped to an 8-bit element-enable code for an external weighted-element converter. With a 3.1872 MHz master clock, the ratios 153 and 95 give 16 steps per cycle at about 1302 Hz for a one and 2097 Hz for a zero. A second, fixed divider makes a 1200 Hz square wave for system timing. All frequencies scale directly with the master clock.

A change of the transmit bit changes only the ratio of the next step. The phase index is never reset by data, so the tone stays phase-continuous across bit boundaries. A standby input forces the code to midscale, which is the converter's idle level. The phase generator keeps running in standby, so the tone resumes at the segment reached.

Top module: `fsk_tone_synth`

## Requirements
- R1: While `rst_n` is low and after its release, `sample_code` is 128, `seg_strobe` is 0 and `clk_1200` is 0. The phase index is 0 and the step ratio is the one-tone ratio: the first step after release lasts 153 cycles whatever `tx_bit` is.
- R2: With `tx_bit` held at 1, `seg_strobe` pulses once every 153 master-clock cycles. The first pulse comes 153 cycles after reset release.
- R3: With `tx_bit` held at 0, `seg_strobe` pulses once every 95 master-clock cycles. This holds from the second step after reset.
- R4: Each `seg_strobe` pulse marks the clock edge at which the phase index k advances by one, modulo 16. On that same edge `sample_code` becomes 128 + round(127·sin(2πk/16)), giving codes 128, 177, 218, 245, 255, 245, 218, 177 for k = 0..7.
- R5: The code is mirrored about midscale. Code(k+8) = 256 − code(k) for k = 1..7, and code(0) = code(8) = 128.
- R6: `tx_bit` is sampled only on the edge where a step ends, and that sample sets the ratio of the next step. A step in progress always completes with its own ratio. A data change never resets the phase index.
- R7: While `tx_off` is 1, `sample_code` is 128 from the first clock edge after `tx_off` rises, and the step timing keeps running. One edge after `tx_off` falls, `sample_code` shows the code of the index that was reached.
- R8: `clk_1200` is low for the first 1328 cycles after reset release, then high for 1328 and low for 1328, repeating with a period of 2656 cycles.
- R9: `seg_strobe` is high for exactly one cycle per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bit | input | 1 | Transmit data bit: 1 selects the lower tone, 0 the higher tone |
| tx_off | input | 1 | Standby: 1 forces the code to midscale |
| sample_code | output | 8 | Element-enable code for the weighted converter |
| seg_strobe | output | 1 | One-cycle pulse when the phase index advances |
| clk_1200 | output | 1 | 1200 Hz square wave (50% duty) |

## Verification
The assertions take it that `tx_bit` and `tx_off` are synchronous to `clk` and always carry a known value. They also take it that both divide ratios are at least 2, so that a step never lasts a single cycle. The bench drives every input on the falling edge of the clock, and it holds each input value for at least one full cycle. It reads outputs on the falling edge, away from the edges at which the state changes.

// File: rtl/fsk_synth_pkg.sv
package fsk_synth_pkg;

    localparam int SEG_BITS  = 4;
    localparam int CODE_BITS = 8;
    localparam int SEG_COUNT = 1 << SEG_BITS;
    localparam int MIDSCALE  = 1 << (CODE_BITS - 1);

    typedef logic [SEG_BITS-1:0]  seg_t;
    typedef logic [CODE_BITS-1:0] code_t;

    // Quarter-wave amplitude for positions 0..4 of a 16-step cycle
    function automatic code_t quarter_amp(input logic [2:0] q);
        code_t a;
        case (q)
            3'd0:    a = 8'd0;
            3'd1:    a = 8'd49;
            3'd2:    a = 8'd90;
            3'd3:    a = 8'd117;
            default: a = 8'd127;
        endcase
        return a;
    endfunction

    // Fold the index into a quarter, then mirror the lower half about midscale
    function automatic code_t seg_to_code(input seg_t s);
        logic [2:0] pos;
        logic [2:0] fold;
        code_t      amp;
        pos  = s[2:0];
        fold = (pos <= 3'd4) ? pos : 3'(4'd8 - {1'b0, pos});
        amp  = quarter_amp(fold);
        return s[3] ? code_t'(MIDSCALE) - amp : code_t'(MIDSCALE) + amp;
    endfunction

endpackage

// File: rtl/fsk_step_divider.sv
module fsk_step_divider #(
    parameter int MARK_DIV  = 153,
    parameter int SPACE_DIV = 95,
    localparam int MAX_DIV  = (MARK_DIV > SPACE_DIV) ? MARK_DIV : SPACE_DIV,
    localparam int CNT_W    = $clog2(MAX_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_bit,
    output logic             step_end,
    output logic [CNT_W-1:0] cnt,
    output logic             sel_mark
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sel;
    } div_st_t;

    localparam logic [CNT_W-1:0] MARK_LAST  = CNT_W'(MARK_DIV - 1);
    localparam logic [CNT_W-1:0] SPACE_LAST = CNT_W'(SPACE_DIV - 1);

    div_st_t st_d, st_q;
    logic    last_hit;

    always_comb begin
        st_d     = st_q;
        last_hit = (st_q.cnt == (st_q.sel ? MARK_LAST : SPACE_LAST));
        if (last_hit) begin
            st_d.cnt = '0;
            st_d.sel = tx_bit;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.sel <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_end = last_hit;
    assign cnt      = st_q.cnt;
    assign sel_mark = st_q.sel;

endmodule

// File: rtl/fsk_phase_seq.sv
module fsk_phase_seq
    import fsk_synth_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    input  logic  tx_off,
    output seg_t  seg,
    output code_t code,
    output logic  strobe
);

    typedef struct packed {
        seg_t  seg;
        code_t code;
        logic  stb;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = advance;
        if (advance) begin
            st_d.seg = st_q.seg + 1'b1;
        end
        st_d.code = tx_off ? code_t'(MIDSCALE) : seg_to_code(st_d.seg);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.seg  <= '0;
            st_q.code <= code_t'(MIDSCALE);
            st_q.stb  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg    = st_q.seg;
    assign code   = st_q.code;
    assign strobe = st_q.stb;

endmodule

// File: rtl/fsk_sys_clkdiv.sv
module fsk_sys_clkdiv #(
    parameter int SYS_DIV = 2656,
    localparam int HALF   = SYS_DIV / 2,
    localparam int CNT_W  = $clog2(HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sq_out,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
    } sys_st_t;

    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);

    sys_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == HALF_LAST) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.lvl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sq_out = st_q.lvl;
    assign cnt    = st_q.cnt;

endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth
    import fsk_synth_pkg::*;
#(
    parameter int MARK_DIV  = 153,
    parameter int SPACE_DIV = 95,
    parameter int SYS_DIV   = 2656,
    localparam int MAX_DIV  = (MARK_DIV > SPACE_DIV) ? MARK_DIV : SPACE_DIV,
    localparam int DCNT_W   = $clog2(MAX_DIV),
    localparam int SCNT_W   = $clog2(SYS_DIV / 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_bit,
    input  logic                 tx_off,
    output logic [CODE_BITS-1:0] sample_code,
    output logic                 seg_strobe,
    output logic                 clk_1200
);

    logic              step_end;
    logic [DCNT_W-1:0] div_cnt;
    logic              div_sel;
    seg_t              seg_idx;
    logic [SCNT_W-1:0] sys_cnt;

    fsk_step_divider #(
        .MARK_DIV  (MARK_DIV),
        .SPACE_DIV (SPACE_DIV)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_bit   (tx_bit),
        .step_end (step_end),
        .cnt      (div_cnt),
        .sel_mark (div_sel)
    );

    fsk_phase_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (step_end),
        .tx_off  (tx_off),
        .seg     (seg_idx),
        .code    (sample_code),
        .strobe  (seg_strobe)
    );

    fsk_sys_clkdiv #(
        .SYS_DIV (SYS_DIV)
    ) u_sys (
        .clk    (clk),
        .rst_n  (rst_n),
        .sq_out (clk_1200),
        .cnt    (sys_cnt)
    );

endmodule

// File: rtl/fsk_tone_synth_chk.sv
module fsk_tone_synth_chk #(
    parameter int MARK_DIV  = 153,
    parameter int SPACE_DIV = 95,
    parameter int SYS_DIV   = 2656,
    parameter int DCNT_W    = 8,
    parameter int SCNT_W    = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_off,
    input logic [7:0]        sample_code,
    input logic              seg_strobe,
    input logic              clk_1200,
    input logic [3:0]        seg_idx,
    input logic              div_sel,
    input logic [DCNT_W-1:0] div_cnt,
    input logic [SCNT_W-1:0] sys_cnt
);

    localparam int MAX_DIV = (MARK_DIV > SPACE_DIV) ? MARK_DIV : SPACE_DIV;

    // R9: a step pulse never lasts two cycles
    p_stb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_strobe |=> !seg_strobe);

    // R4: every pulse comes with the index moved on by exactly one
    p_seg_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_strobe |-> seg_idx == 4'($past(seg_idx) + 4'd1));

    // R6: the index moves only at a step end, never on a data change
    p_seg_only_on_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_idx != $past(seg_idx)) |-> seg_strobe);

    // R6: the ratio choice is updated only at a step end
    p_sel_only_on_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel != $past(div_sel)) |-> seg_strobe);

    // R7: standby seen on the previous edge means midscale now
    p_standby_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_off) |-> sample_code == 8'd128);

    // R2: the step counter stays below the larger ratio
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(div_cnt) < MAX_DIV);

    // R8: the square wave flips only after a full half period
    p_clk_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_1200 != $past(clk_1200)) |-> int'($past(sys_cnt)) == SYS_DIV / 2 - 1);

endmodule

bind fsk_tone_synth fsk_tone_synth_chk #(
    .MARK_DIV  (MARK_DIV),
    .SPACE_DIV (SPACE_DIV),
    .SYS_DIV   (SYS_DIV),
    .DCNT_W    (DCNT_W),
    .SCNT_W    (SCNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_off      (tx_off),
    .sample_code (sample_code),
    .seg_strobe  (seg_strobe),
    .clk_1200    (clk_1200),
    .seg_idx     (seg_idx),
    .div_sel     (div_sel),
    .div_cnt     (div_cnt),
    .sys_cnt     (sys_cnt)
);

// File: tb/fsk_tone_synth_bench.sv
`timescale 1ns/1ps
module fsk_tone_synth_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_bit = 1'b1;
    logic       tx_off = 1'b0;
    logic [7:0] sample_code;
    logic       seg_strobe;
    logic       clk_1200;

    int checks = 0;
    int fails  = 0;
    int idx    = 0;
    int obs [16];

    always #2.5 clk = ~clk;

    fsk_tone_synth u_fsk_tone_synth (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_bit      (tx_bit),
        .tx_off      (tx_off),
        .sample_code (sample_code),
        .seg_strobe  (seg_strobe),
        .clk_1200    (clk_1200)
    );

    function automatic int exp_code(input int k);
        real v;
        v = 127.0 * $sin(2.0 * 3.14159265358979 * k / 16.0);
        return 128 + $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Count falling edges until the strobe is seen high; advance the tracked index
    task automatic wait_stb(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!seg_strobe && n < 5000);
        idx = (idx + 1) % 16;
    endtask

    task automatic do_reset(input logic bit_in);
        @(negedge clk);
        rst_n  = 1'b0;
        tx_bit = bit_in;
        tx_off = 1'b0;
        repeat (4) @(negedge clk);
        idx = 0;
    endtask

    task automatic t_reset();
        int n;
        do_reset(1'b0);
        chk("R1", "code in reset", int'(sample_code), 128);
        chk("R1", "strobe in reset", int'(seg_strobe), 0);
        chk("R1", "clk_1200 in reset", int'(clk_1200), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "code after release", int'(sample_code), 128);
        wait_stb(n);
        chk("R1", "first step uses one-tone ratio", n + 1, 153);
        chk("R4", "code at index 1", int'(sample_code), exp_code(1));
        wait_stb(n);
        chk("R3", "zero-tone step length", n, 95);
    endtask

    task automatic t_mark_wave();
        int n;
        do_reset(1'b1);
        rst_n = 1'b1;
        wait_stb(n);
        chk("R2", "first one-tone step", n, 153);
        obs[idx] = int'(sample_code);
        for (int s = 0; s < 15; s++) begin
            @(negedge clk);
            chk("R9", "strobe width", int'(seg_strobe), 0);
            wait_stb(n);
            chk("R2", "one-tone step length", n + 1, 153);
            chk("R4", $sformatf("code at index %0d", idx), int'(sample_code), exp_code(idx));
            obs[idx] = int'(sample_code);
        end
        chk("R5", "code at index 0", obs[0], 128);
        chk("R5", "code at index 8", obs[8], 128);
        for (int k = 1; k < 8; k++) begin
            chk("R5", $sformatf("mirror pair %0d", k), obs[k] + obs[k + 8], 256);
        end
    endtask

    task automatic t_space();
        int n;
        do_reset(1'b0);
        rst_n = 1'b1;
        wait_stb(n);
        for (int s = 0; s < 6; s++) begin
            wait_stb(n);
            chk("R3", "zero-tone step length", n, 95);
            chk("R4", "code follows index", int'(sample_code), exp_code(idx));
        end
    endtask

    task automatic t_switch();
        int n;
        do_reset(1'b1);
        rst_n = 1'b1;
        wait_stb(n);
        wait_stb(n);
        repeat (20) @(negedge clk);
        tx_bit = 1'b0;
        wait_stb(n);
        chk("R6", "step in progress keeps its ratio", n + 20, 153);
        chk("R6", "index continues across data change", int'(sample_code), exp_code(idx));
        tx_bit = 1'b1;
        wait_stb(n);
        chk("R6", "new ratio from next step", n, 95);
        wait_stb(n);
        chk("R6", "back to one-tone ratio", n, 153);
        chk("R6", "index continues after switch back", int'(sample_code), exp_code(idx));
    endtask

    task automatic t_standby();
        int n;
        do_reset(1'b1);
        rst_n = 1'b1;
        wait_stb(n);
        wait_stb(n);
        wait_stb(n);
        tx_off = 1'b1;
        @(negedge clk);
        chk("R7", "code forced to midscale", int'(sample_code), 128);
        wait_stb(n);
        chk("R7", "step timing runs in standby", n + 1, 153);
        chk("R7", "code midscale at step", int'(sample_code), 128);
        repeat (10) @(negedge clk);
        tx_off = 1'b0;
        @(negedge clk);
        chk("R7", "code resumes at reached index", int'(sample_code), exp_code(idx));
    endtask

    task automatic t_sysclk();
        int n;
        do_reset(1'b1);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!clk_1200 && n < 4000);
        chk("R8", "first low span", n, 1328);
        n = 0;
        do begin @(negedge clk); n++; end while (clk_1200 && n < 4000);
        chk("R8", "high span", n, 1328);
        n = 0;
        do begin @(negedge clk); n++; end while (!clk_1200 && n < 4000);
        chk("R8", "low span", n, 1328);
    endtask

    initial begin
        t_reset();
        t_mark_wave();
        t_space();
        t_switch();
        t_standby();
        t_sysclk();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule